// File: doc/BRIEF.md
# Flash Burst Block Read Sequencer

This block sits on the host side of a flash device that has a multiplexed register bus. It runs a synchronous burst block read over several pages. On a start request it captures the block address, die select, start page and page count. It then issues a fixed series of register writes: it sets up the block, the die, the page and the buffer, sets the page count, clears the interrupt and writes the block-read command.

After the command, the sequencer is paced by the device interrupt line. A rising edge means a page is ready in one of two on-chip data buffers. The sequencer reads a parameterized number of words from that buffer and streams each word out with a valid strobe. The device then lowers the interrupt while it fetches the next page, and during that time chip enable is released so the host may use the bus for other devices. Pages come from buffer 0 and buffer 1 in turn.

After the last page, the sequencer reads the controller status word and ends with a one-cycle done pulse. An error flag accompanies that pulse when the status error bit is set, or when an interrupt edge fails to arrive within a timeout.

Top module: `fbr_seq`

## Requirements
- R1: After start, exactly seven bus writes occur, in this order: F100h (block address input), F101h (die select in bit 15, other bits 0), F107h (start page in bits 7:2, bits 1:0 zero), F200h, F104h (page count zero-extended), F241h, F220h.
- R2: The F200h write carries 0800h: the buffer start field in bits 11:8 is 1000b, and the buffer count field in bits 1:0 and all other bits are 0.
- R3: The interrupt clear (0000h to F241h) is written directly before the command write of 000Ah to F220h. No bus read and no bus write occur in the same cycle.
- R4: Page k (counting from 0) is read from buffer k mod 2, as WORDS reads of consecutive addresses from that buffer's base. Each returned word appears once on str_data with str_valid, in read order.
- R5: A page's buffer reads start only after a rising edge of int_in. Each later page also waits for a falling edge and then a new rising edge. No buffer read is issued while int_in is low.
- R6: chip_en is high on every cycle with a bus read or write. It is low within two cycles after the sequencer begins waiting for a rising edge, and stays low until that edge arrives.
- R7: The number of pages read equals page_cnt. A page_cnt of 0 reads one page.
- R8: After the final page, F240h is read once. done then pulses for exactly one cycle, and err is high with it exactly when bit 10 of the status word is 1. err is never high without done.
- R9: A start request while busy is ignored: it causes no extra bus traffic and no change to the running operation.
- R10: If a wait for an interrupt edge exceeds TMO_CYC cycles, the sequencer returns to idle with done and err both high, and without reading F240h.
- R11: After reset the sequencer is idle: busy, done, err, chip_en, bus_we, bus_re and str_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled only when idle |
| blk_addr | input | 16 | Block address word for F100h |
| die_sel | input | 1 | Die select bit for F101h |
| page_start | input | 6 | Start page number for F107h |
| page_cnt | input | CNT_W | Number of pages to read (0 reads one page) |
| bus_addr | output | 16 | Register bus address |
| bus_wdata | output | 16 | Register bus write data |
| bus_we | output | 1 | Register bus write strobe |
| bus_re | output | 1 | Register bus read strobe |
| bus_rdata | input | 16 | Read data, valid the cycle after bus_re |
| int_in | input | 1 | Device interrupt line |
| chip_en | output | 1 | Device chip enable, active high |
| str_data | output | 16 | Streamed buffer word |
| str_valid | output | 1 | Strobe for str_data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Failure flag, high only with done |

## Verification
The assertions take for granted that bus_rdata answers a read exactly one cycle after bus_re. They also take for granted that int_in rises only while the sequencer waits for it, and falls only after all the reads of the current page. The bench's device model keeps within this. It raises the interrupt several cycles after the command, or after its own falling edge. It lowers the interrupt only once it has counted WORDS buffer reads. In the timeout case it simply never raises the line again.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WR, S_RISE, S_READ, S_FALL, S_STAT, S_SWAIT
  } st_t;

  localparam logic [15:0] A_BLK   = 16'hF100;
  localparam logic [15:0] A_DSEL  = 16'hF101;
  localparam logic [15:0] A_PAGE  = 16'hF107;
  localparam logic [15:0] A_BUFC  = 16'hF200;
  localparam logic [15:0] A_CNT   = 16'hF104;
  localparam logic [15:0] A_INT   = 16'hF241;
  localparam logic [15:0] A_CMD   = 16'hF220;
  localparam logic [15:0] A_STAT  = 16'hF240;
  localparam logic [15:0] CMD_BLKRD = 16'h000A;
  localparam logic [15:0] BUFC_VAL  = 16'h0800;
  localparam int          ERR_BIT   = 10;
  localparam int          NUM_WR    = 7;
endpackage

// File: rtl/fbr_edge.sv
module fbr_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic q;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= lvl;
  end

  assign rise = lvl & ~q;
  assign fall = ~lvl & q;

  // R5: a rising edge is reported only when the line was low on the previous cycle
  a_r5_rise_from_low: assert property (@(posedge clk) disable iff (rst)
    rise |-> !$past(lvl));
endmodule

// File: rtl/fbr_timer.sv
module fbr_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run || clr) cnt <= '0;
    else if (!expired)      cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == CW'(LIMIT));

  // R10: the wait counter never passes its limit
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    expired |=> (cnt == '0) || expired);
endmodule

// File: rtl/fbr_seq.sv
module fbr_seq
  import fbr_pkg::*;
#(
  parameter int          WORDS     = 4,
  parameter int          CNT_W     = 8,
  parameter int          TMO_CYC   = 1000,
  parameter logic [15:0] BUF0_ADDR = 16'h0200,
  parameter logic [15:0] BUF1_ADDR = 16'h0600
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [15:0]      blk_addr,
  input  logic             die_sel,
  input  logic [5:0]       page_start,
  input  logic [CNT_W-1:0] page_cnt,
  output logic [15:0]      bus_addr,
  output logic [15:0]      bus_wdata,
  output logic             bus_we,
  output logic             bus_re,
  input  logic [15:0]      bus_rdata,
  input  logic             int_in,
  output logic             chip_en,
  output logic [15:0]      str_data,
  output logic             str_valid,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int MAXI  = (WORDS > NUM_WR) ? WORDS : NUM_WR;
  localparam int IDX_W = $clog2(MAXI);

  st_t              state, st_n;
  logic [IDX_W-1:0] widx;
  logic [CNT_W-1:0] pg, cnt_q;
  logic [15:0]      blk_q;
  logic             die_q, bsel, rd_buf, str_d, stat_d;
  logic [5:0]       pst_q;
  logic             rise_ev, fall_ev, tmo;
  logic [15:0]      wr_addr, wr_data;
  logic             last_word, last_page;

  fbr_edge u_edge (.clk(clk), .rst(rst), .lvl(int_in), .rise(rise_ev), .fall(fall_ev));

  fbr_timer #(.LIMIT(TMO_CYC)) u_tmo (
    .clk(clk), .rst(rst),
    .run((state == S_RISE) || (state == S_FALL)),
    .clr(rise_ev | fall_ev),
    .expired(tmo)
  );

  assign last_word = (widx == IDX_W'(WORDS - 1));
  assign last_page = (({1'b0, pg} + (CNT_W+1)'(1)) >= {1'b0, cnt_q});
  assign busy      = (state != S_IDLE);

  always_comb begin
    case (widx)
      IDX_W'(0): begin wr_addr = A_BLK;  wr_data = blk_q;                  end
      IDX_W'(1): begin wr_addr = A_DSEL; wr_data = {die_q, 15'b0};         end
      IDX_W'(2): begin wr_addr = A_PAGE; wr_data = {8'h00, pst_q, 2'b00};  end
      IDX_W'(3): begin wr_addr = A_BUFC; wr_data = BUFC_VAL;               end
      IDX_W'(4): begin wr_addr = A_CNT;  wr_data = 16'(cnt_q);             end
      IDX_W'(5): begin wr_addr = A_INT;  wr_data = 16'h0000;               end
      default:   begin wr_addr = A_CMD;  wr_data = CMD_BLKRD;              end
    endcase
  end

  always_comb begin
    st_n = state;
    case (state)
      S_IDLE:  if (start) st_n = S_WR;
      S_WR:    if (widx == IDX_W'(NUM_WR - 1)) st_n = S_RISE;
      S_RISE:  if (rise_ev) st_n = S_READ; else if (tmo) st_n = S_IDLE;
      S_READ:  if (last_word) st_n = last_page ? S_STAT : S_FALL;
      S_FALL:  if (fall_ev) st_n = S_RISE; else if (tmo) st_n = S_IDLE;
      S_STAT:  st_n = S_SWAIT;
      S_SWAIT: if (stat_d) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; widx <= '0; pg <= '0; cnt_q <= '0; blk_q <= '0;
      die_q <= 1'b0; pst_q <= '0; bsel <= 1'b0; rd_buf <= 1'b0;
      str_d <= 1'b0; stat_d <= 1'b0; bus_addr <= '0; bus_wdata <= '0;
      bus_we <= 1'b0; bus_re <= 1'b0; chip_en <= 1'b0;
      str_data <= '0; str_valid <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      state     <= st_n;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      chip_en   <= (state != S_IDLE) && (state != S_RISE);
      str_d     <= bus_re && rd_buf;
      stat_d    <= bus_re && !rd_buf;
      str_valid <= str_d;
      if (str_d) str_data <= bus_rdata;
      case (state)
        S_IDLE: if (start) begin
          blk_q <= blk_addr; die_q <= die_sel; pst_q <= page_start;
          cnt_q <= page_cnt; widx <= '0; pg <= '0; bsel <= 1'b0;
        end
        S_WR: begin
          bus_we    <= 1'b1;
          bus_addr  <= wr_addr;
          bus_wdata <= wr_data;
          widx      <= (widx == IDX_W'(NUM_WR - 1)) ? '0 : widx + 1'b1;
        end
        S_READ: begin
          bus_re   <= 1'b1;
          rd_buf   <= 1'b1;
          bus_addr <= (bsel ? BUF1_ADDR : BUF0_ADDR) + 16'(widx);
          if (last_word) begin
            widx <= '0;
            pg   <= pg + 1'b1;
            bsel <= ~bsel;
          end else begin
            widx <= widx + 1'b1;
          end
        end
        S_STAT: begin
          bus_re   <= 1'b1;
          rd_buf   <= 1'b0;
          bus_addr <= A_STAT;
        end
        S_SWAIT: if (stat_d) begin
          done <= 1'b1;
          err  <= bus_rdata[ERR_BIT];
        end
        S_RISE: if (!rise_ev && tmo) begin done <= 1'b1; err <= 1'b1; end
        S_FALL: if (!fall_ev && tmo) begin done <= 1'b1; err <= 1'b1; end
        default: ;
      endcase
    end
  end

  // R3: read and write strobes never share a cycle
  a_r3_no_rw_overlap: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re));
  // R6: the device is selected for every bus access
  a_r6_ce_on_access: assert property (@(posedge clk) disable iff (rst)
    (bus_we || bus_re) |-> chip_en);
  // R6: once the interrupt falls after a page, chip enable drops two cycles later
  a_r6_ce_drop: assert property (@(posedge clk) disable iff (rst)
    (state == S_FALL && fall_ev) |=> ##1 !chip_en);
  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: err never appears without done
  a_r8_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  // R9: a start request while busy leaves the captured count unchanged
  a_r9_start_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(cnt_q));
endmodule

// File: tb/test_fbr_seq.sv
module test_fbr_seq;
  localparam int          WORDS = 4;
  localparam int          CNT_W = 8;
  localparam int          TMO   = 100;
  localparam logic [15:0] BUF0  = 16'h0200;
  localparam logic [15:0] BUF1  = 16'h0600;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, start, die_sel, int_in;
  logic [15:0] blk_addr, bus_addr, bus_wdata, bus_rdata, str_data;
  logic [5:0]  page_start;
  logic [CNT_W-1:0] page_cnt;
  logic bus_we, bus_re, chip_en, str_valid, busy, done, err;

  fbr_seq #(.WORDS(WORDS), .CNT_W(CNT_W), .TMO_CYC(TMO), .BUF0_ADDR(BUF0), .BUF1_ADDR(BUF1)) i_fbr_seq (
    .clk(clk), .rst(rst), .start(start), .blk_addr(blk_addr), .die_sel(die_sel),
    .page_start(page_start), .page_cnt(page_cnt), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .int_in(int_in), .chip_en(chip_en),
    .str_data(str_data), .str_valid(str_valid), .busy(busy), .done(done), .err(err)
  );

  int total = 0, bad = 0;
  logic [31:0] exp_wr[$];
  logic [15:0] exp_st[$];
  logic [15:0] stat_reg = 16'h0000;
  int dev_pg = 0, rd_cnt = 0, bad_rd = 0, stat_rd = 0, done_cnt = 0;
  logic done_err = 1'b0, done_prev = 1'b0;
  bit cmd_seen = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string wtag(input logic [15:0] a);
    if (a == 16'hF200) return "R2";
    if (a == 16'hF241 || a == 16'hF220) return "R3";
    return "R1";
  endfunction

  // device register and buffer model: data valid the cycle after a read
  always @(posedge clk)
    if (bus_re) bus_rdata <= (bus_addr == 16'hF240) ? stat_reg : bus_addr + 16'(dev_pg << 12);

  // monitor: pops the scoreboard as the design produces bus traffic and stream words
  always @(negedge clk) begin : mon
    logic [31:0] e;
    if (!rst) begin
      if (bus_we) begin
        if (exp_wr.size() == 0) chk(1'b0, wtag(bus_addr), "unexpected write", {bus_addr, bus_wdata}, 0);
        else begin
          e = exp_wr.pop_front();
          chk({bus_addr, bus_wdata} == e, wtag(e[31:16]), "write", {bus_addr, bus_wdata}, e);
        end
        if (bus_addr == 16'hF220 && bus_wdata == 16'h000A) cmd_seen = 1'b1;
      end
      if (bus_we || bus_re) chk(chip_en, "R6", "chip_en on access", {31'b0, chip_en}, 1);
      if (bus_re) begin
        if (bus_addr == 16'hF240) stat_rd++;
        else begin
          rd_cnt++;
          if (!int_in) bad_rd++;
        end
      end
      if (str_valid) begin
        if (exp_st.size() == 0) chk(1'b0, "R4", "unexpected stream word", {16'b0, str_data}, 0);
        else begin
          e = {16'b0, exp_st.pop_front()};
          chk({16'b0, str_data} == e, "R4", "stream word", {16'b0, str_data}, e);
        end
      end
      if (done) begin
        done_cnt++;
        done_err = err;
        chk(!done_prev, "R8", "done pulse width", {31'b0, done_prev}, 0);
      end
      done_prev = done;
    end
  end

  task automatic push_op(input logic [15:0] blk, input logic die, input logic [5:0] pst,
                         input logic [CNT_W-1:0] cnt, input int serve);
    exp_wr.push_back({16'hF100, blk});
    exp_wr.push_back({16'hF101, die, 15'b0});
    exp_wr.push_back({16'hF107, 8'h00, pst, 2'b00});
    exp_wr.push_back({16'hF200, 16'h0800});
    exp_wr.push_back({16'hF104, 16'(cnt)});
    exp_wr.push_back({16'hF241, 16'h0000});
    exp_wr.push_back({16'hF220, 16'h000A});
    for (int p = 0; p < serve; p++)
      for (int i = 0; i < WORDS; i++)
        exp_st.push_back(((p % 2) ? BUF1 : BUF0) + 16'(i) + 16'(p << 12));
  endtask

  task automatic dev(input int serve, input int pages);
    wait (cmd_seen);
    cmd_seen = 1'b0;
    for (int p = 0; p < serve; p++) begin
      repeat (6) @(negedge clk);
      chk(!chip_en, "R6", "chip_en while waiting for rise", {31'b0, chip_en}, 0);
      dev_pg = p;
      rd_cnt = 0;
      int_in = 1'b1;
      while (rd_cnt < WORDS) @(negedge clk);
      repeat (3) @(negedge clk);
      if (p < pages - 1) int_in = 1'b0;
    end
  endtask

  task automatic run_op(input logic [15:0] blk, input logic die, input logic [5:0] pst,
                        input logic [CNT_W-1:0] cnt, input logic [15:0] stat, input int serve,
                        input bit exp_err, input bit busy_start, input string req);
    int pages, s0, d0, n;
    pages = (cnt == 0) ? 1 : int'(cnt);
    stat_reg = stat;
    push_op(blk, die, pst, cnt, serve);
    s0 = stat_rd; d0 = done_cnt; bad_rd = 0;
    @(negedge clk);
    blk_addr = blk; die_sel = die; page_start = pst; page_cnt = cnt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fork
      dev(serve, pages);
      begin
        n = 0;
        while (done_cnt == d0 && n < 3000) begin @(negedge clk); n++; end
      end
      if (busy_start) begin
        repeat (30) @(negedge clk);
        blk_addr = 16'h5555; page_cnt = 8'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    chk(done_cnt == d0 + 1, req, "done count", done_cnt - d0, 1);
    chk(done_err == exp_err, req, "err flag", {31'b0, done_err}, {31'b0, exp_err});
    chk(stat_rd - s0 == ((serve == pages) ? 1 : 0), req, "status reads", stat_rd - s0, (serve == pages) ? 1 : 0);
    chk(bad_rd == 0, "R5", "buffer reads with interrupt low", bad_rd, 0);
    repeat (20) @(negedge clk);
    chk(exp_wr.size() == 0, "R1", "writes left over", exp_wr.size(), 0);
    chk(exp_st.size() == 0, "R7", "stream words left over", exp_st.size(), 0);
    chk(!busy, busy_start ? "R9" : req, "busy after end", {31'b0, busy}, 0);
    int_in = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; int_in = 1'b0; blk_addr = '0; die_sel = 1'b0;
    page_start = '0; page_cnt = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: idle outputs after reset
    chk(!busy && !done && !err && !chip_en && !bus_we && !bus_re && !str_valid, "R11", "reset state",
        {25'b0, busy, done, err, chip_en, bus_we, bus_re, str_valid}, 0);
    // R4 R8 R9: three pages, clean status, start pulse while busy
    run_op(16'h1234, 1'b0, 6'd5, 8'd3, 16'h0000, 3, 1'b0, 1'b1, "R8");
    // R7: page count 0 reads one page; R8: status bit 10 set gives err
    run_op(16'h00AB, 1'b1, 6'd0, 8'd0, 16'h0400, 1, 1'b1, 1'b0, "R7");
    // R8: all status bits but 10 set, no error
    run_op(16'hBEEF, 1'b1, 6'd63, 8'd2, 16'hFBFF, 2, 1'b0, 1'b0, "R8");
    // R10: second interrupt rise never arrives
    run_op(16'h0F0F, 1'b0, 6'd9, 8'd2, 16'h0000, 1, 1'b1, 1'b0, "R10");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule